// File: doc/BRIEF.md
# Single-Entry Posted Write Buffer

This block sits between a CPU and a RAM controller and holds one posted write. A CPU write is acknowledged in the same cycle it is presented whenever the buffer can take it. The buffer then presents the stored address, data and byte enables to the RAM controller until the controller reports completion. The CPU does not wait for the RAM.

CPU reads go straight through to the RAM controller, but only while the buffer is empty. Because every read waits for the pending write, a read can never return data older than a write the CPU has already been told is done. A companion cache gets an update strobe carrying the written address, data and byte enables in the cycle the write is accepted, so the cache stays coherent with the posted data.

The RAM controller uses one completion pulse, `ram_done`. While the buffer is occupied, that pulse completes the buffered write. While the buffer is empty, it completes the read in flight.

Top module: `posted_wr_buf`

## Requirements
- R1: A CPU write (`cpu_wr`=1) presented while the buffer is empty gets `cpu_ack`=1 in that same cycle, and the buffer is occupied from the next cycle.
- R2: A CPU write presented while the buffer is occupied and `ram_done`=0 gets `cpu_ack`=0 and does not change the buffered address, data or byte enables.
- R3: A CPU write presented while the buffer is occupied and `ram_done`=1 is acknowledged in that cycle and replaces the buffer contents, so the buffer stays occupied.
- R4: `ram_wr_req` is 1 exactly while the buffer is occupied. During that time `ram_addr` and `ram_wdata` show the buffered address and data, held stable until `ram_done`.
- R5: While the buffer is occupied, `ram_rd_req`=0 and a CPU read is not acknowledged, even in the cycle where `ram_done`=1 completes the write.
- R6: When the buffer is empty, a CPU read drives `ram_rd_req`=1 and `ram_addr`=`cpu_addr`. It gets `cpu_ack`=1 in the cycle `ram_done`=1, and `cpu_rdata` equals `ram_rdata`.
- R7: `cache_upd` is 1 exactly in the cycles a write is acknowledged, with `cache_addr`, `cache_data` and `cache_be` equal to that cycle's CPU address, data and byte enables. A stalled write raises no update.
- R8: The byte enables captured with a write appear unchanged on `ram_be` while that write is pending.
- R9: If `cpu_wr` and `cpu_rd` are both 1, the write is served, and no read is issued (`ram_rd_req`=0) in that cycle.
- R10: Reset (`rst_n`=0) empties the buffer: after reset `ram_wr_req`=0, and a write that had not completed is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | CPU write strobe, held until acknowledged |
| cpu_rd | input | 1 | CPU read strobe, held until acknowledged |
| cpu_addr | input | AW | CPU word address |
| cpu_wdata | input | DW | CPU write data |
| cpu_be | input | DW/8 | CPU byte enables |
| cpu_ack | output | 1 | Access acknowledged this cycle |
| cpu_rdata | output | DW | Read data returned to the CPU |
| ram_wr_req | output | 1 | Buffered write pending toward RAM |
| ram_rd_req | output | 1 | Read request toward RAM |
| ram_addr | output | AW | RAM address |
| ram_wdata | output | DW | RAM write data |
| ram_be | output | DW/8 | RAM byte enables |
| ram_done | input | 1 | RAM completion pulse for the current request |
| ram_rdata | input | DW | RAM read data |
| cache_upd | output | 1 | Cache update strobe |
| cache_addr | output | AW | Cache update address |
| cache_data | output | DW | Cache update data |
| cache_be | output | DW/8 | Cache update byte enables |

## Verification
The bench builds the buffer with AW=8 and DW=16, so there are two byte-enable lanes. With two lanes, single-lane, other-lane and full-word enables can all be told apart on `ram_be` and `cache_be`. The narrow address lets a short vector table name each address outright. This makes the aliasing cases easy to exercise: a read to a different address arriving in the very cycle the pending write completes, back-to-back writes that replace the buffer on the done pulse, and simultaneous read and write strobes.

// File: rtl/posted_wr_buf.sv
module posted_wr_buf #(
  parameter int AW = 24,
  parameter int DW = 16,
  localparam int BW = DW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_wr,
  input  logic          cpu_rd,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  input  logic [BW-1:0] cpu_be,
  output logic          cpu_ack,
  output logic [DW-1:0] cpu_rdata,
  output logic          ram_wr_req,
  output logic          ram_rd_req,
  output logic [AW-1:0] ram_addr,
  output logic [DW-1:0] ram_wdata,
  output logic [BW-1:0] ram_be,
  input  logic          ram_done,
  input  logic [DW-1:0] ram_rdata,
  output logic          cache_upd,
  output logic [AW-1:0] cache_addr,
  output logic [DW-1:0] cache_data,
  output logic [BW-1:0] cache_be
);

  logic          full;
  logic [AW-1:0] b_addr;
  logic [DW-1:0] b_data;
  logic [BW-1:0] b_be;

  wire wr_take = cpu_wr & (~full | ram_done);
  wire rd_go   = cpu_rd & ~cpu_wr & ~full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full   <= 1'b0;
      b_addr <= '0;
      b_data <= '0;
      b_be   <= '0;
    end else if (wr_take) begin
      full   <= 1'b1;
      b_addr <= cpu_addr;
      b_data <= cpu_wdata;
      b_be   <= cpu_be;
    end else if (full && ram_done) begin
      full <= 1'b0;
    end
  end

  assign cpu_ack    = wr_take | (rd_go & ram_done);
  assign cpu_rdata  = ram_rdata;
  assign ram_wr_req = full;
  assign ram_rd_req = rd_go;
  assign ram_addr   = full ? b_addr : cpu_addr;
  assign ram_wdata  = b_data;
  assign ram_be     = b_be;
  assign cache_upd  = wr_take;
  assign cache_addr = cpu_addr;
  assign cache_data = cpu_wdata;
  assign cache_be   = cpu_be;

endmodule

// File: rtl/posted_wr_buf_chk.sv
module posted_wr_buf_chk #(
  parameter int AW = 24,
  parameter int DW = 16,
  localparam int BW = DW / 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_wr,
  input logic          cpu_rd,
  input logic [BW-1:0] cpu_be,
  input logic          cpu_ack,
  input logic          ram_wr_req,
  input logic          ram_rd_req,
  input logic [AW-1:0] ram_addr,
  input logic [DW-1:0] ram_wdata,
  input logic [BW-1:0] ram_be,
  input logic          ram_done,
  input logic          cache_upd
);

  // R2
  stall_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_wr_req && !ram_done && cpu_wr) |-> !cpu_ack);

  // R5
  no_read_while_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_wr_req |-> !ram_rd_req);

  // R1
  occupied_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_ack) |=> ram_wr_req);

  // R4
  pending_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_wr_req && !ram_done && !cpu_wr) |=>
      (ram_wr_req && $stable(ram_addr) && $stable(ram_wdata)));

  // R7
  cache_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cache_upd |-> (cpu_ack && cpu_wr));

  // R8
  be_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_ack) |=> (ram_be == $past(cpu_be)));

  // R9
  write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_rd) |-> !ram_rd_req);

endmodule

bind posted_wr_buf posted_wr_buf_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
  .cpu_be(cpu_be), .cpu_ack(cpu_ack), .ram_wr_req(ram_wr_req),
  .ram_rd_req(ram_rd_req), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
  .ram_be(ram_be), .ram_done(ram_done), .cache_upd(cache_upd)
);

// File: tb/posted_wr_buf_bench.sv
module posted_wr_buf_bench;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int BW = DW / 8;
  localparam int NV = 14;
  localparam int VW = 89;

  logic clk = 0, rst_n = 0;
  logic cpu_wr = 0, cpu_rd = 0, ram_done = 0;
  logic [AW-1:0] cpu_addr = 0;
  logic [DW-1:0] cpu_wdata = 0, ram_rdata = 0;
  logic [BW-1:0] cpu_be = 0;
  logic cpu_ack, ram_wr_req, ram_rd_req, cache_upd;
  logic [DW-1:0] cpu_rdata, ram_wdata, cache_data;
  logic [AW-1:0] ram_addr, cache_addr;
  logic [BW-1:0] ram_be, cache_be;

  int nvec = 0, nbad = 0;

  always #2 clk = ~clk;

  posted_wr_buf #(.AW(AW), .DW(DW)) u_posted_wr_buf (.*);

  // in: wr rd done addr data be rdata | exp: ack wreq rreq raddr rwdata cpu_rdata cupd
  localparam logic [VW-1:0] VEC [NV] = '{
    {3'b000, 8'h00, 16'h0000, 2'b00, 16'h0000, 3'b000, 8'h00, 16'h0000, 16'h0000, 1'b0},
    {3'b100, 8'h10, 16'h1111, 2'b11, 16'h0000, 3'b100, 8'h10, 16'h0000, 16'h0000, 1'b1},
    {3'b010, 8'h20, 16'h0000, 2'b00, 16'h0000, 3'b010, 8'h10, 16'h1111, 16'h0000, 1'b0},
    {3'b011, 8'h20, 16'h0000, 2'b00, 16'h0000, 3'b010, 8'h10, 16'h1111, 16'h0000, 1'b0},
    {3'b010, 8'h20, 16'h0000, 2'b00, 16'h0000, 3'b001, 8'h20, 16'h1111, 16'h0000, 1'b0},
    {3'b011, 8'h20, 16'h0000, 2'b00, 16'hABCD, 3'b101, 8'h20, 16'h1111, 16'hABCD, 1'b0},
    {3'b100, 8'h30, 16'h2222, 2'b01, 16'h0000, 3'b100, 8'h30, 16'h1111, 16'h0000, 1'b1},
    {3'b100, 8'h40, 16'h3333, 2'b10, 16'h0000, 3'b010, 8'h30, 16'h2222, 16'h0000, 1'b0},
    {3'b101, 8'h40, 16'h3333, 2'b10, 16'h0000, 3'b110, 8'h30, 16'h2222, 16'h0000, 1'b1},
    {3'b000, 8'h00, 16'h0000, 2'b00, 16'h0000, 3'b010, 8'h40, 16'h3333, 16'h0000, 1'b0},
    {3'b001, 8'h00, 16'h0000, 2'b00, 16'h0000, 3'b010, 8'h40, 16'h3333, 16'h0000, 1'b0},
    {3'b110, 8'h50, 16'h4444, 2'b11, 16'h0000, 3'b100, 8'h50, 16'h3333, 16'h0000, 1'b1},
    {3'b001, 8'h00, 16'h0000, 2'b00, 16'h0000, 3'b010, 8'h50, 16'h4444, 16'h0000, 1'b0},
    {3'b000, 8'h00, 16'h0000, 2'b00, 16'h0000, 3'b000, 8'h00, 16'h4444, 16'h0000, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic w, input logic r, input logic d, input logic [AW-1:0] a,
                       input logic [DW-1:0] dt, input logic [BW-1:0] b, input logic [DW-1:0] rd);
    @(posedge clk); #1;
    cpu_wr = w; cpu_rd = r; ram_done = d; cpu_addr = a; cpu_wdata = dt; cpu_be = b; ram_rdata = rd;
    @(negedge clk);
  endtask

  initial begin
    #400000;
    nbad++;
    $display("FAIL watchdog: got hang expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R10 reset empty", {31'd0, ram_wr_req}, 0);

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      drive(v[88], v[87], v[86], v[85:78], v[77:62], v[61:60], v[59:44]);
      chk("R1/R3/R9 cpu_ack", {31'd0, cpu_ack}, {31'd0, v[43]});
      chk("R4 ram_wr_req", {31'd0, ram_wr_req}, {31'd0, v[42]});
      chk("R5/R6 ram_rd_req", {31'd0, ram_rd_req}, {31'd0, v[41]});
      chk("R4/R6 ram_addr", {24'd0, ram_addr}, {24'd0, v[40:33]});
      chk("R4 ram_wdata", {16'd0, ram_wdata}, {16'd0, v[32:17]});
      chk("R6 cpu_rdata", {16'd0, cpu_rdata}, {16'd0, v[16:1]});
      chk("R7 cache_upd", {31'd0, cache_upd}, {31'd0, v[0]});
    end

    // R7 and R8 directed: cache fields and byte-enable carry
    drive(1, 0, 0, 8'h66, 16'h5A5A, 2'b01, 0);
    chk("R7 cache_addr", {24'd0, cache_addr}, 32'h66);
    chk("R7 cache_data", {16'd0, cache_data}, 32'h5A5A);
    chk("R7 cache_be", {30'd0, cache_be}, 32'h1);
    drive(0, 0, 0, 0, 0, 0, 0);
    chk("R8 ram_be lane0", {30'd0, ram_be}, 32'h1);
    drive(1, 0, 1, 8'h67, 16'hA5A5, 2'b10, 0);
    chk("R3 ack on done", {31'd0, cpu_ack}, 1);
    drive(0, 0, 0, 0, 0, 0, 0);
    chk("R8 ram_be lane1", {30'd0, ram_be}, 32'h2);
    chk("R3 new addr", {24'd0, ram_addr}, 32'h67);

    // R2: stalled write leaves buffer unchanged
    drive(1, 0, 0, 8'h99, 16'hFFFF, 2'b11, 0);
    chk("R2 stall ack", {31'd0, cpu_ack}, 0);
    chk("R7 no update on stall", {31'd0, cache_upd}, 0);
    drive(0, 0, 0, 0, 0, 0, 0);
    chk("R2 buffer kept", {8'd0, ram_addr, ram_wdata}, {8'd0, 8'h67, 16'hA5A5});

    // R10: reset drops pending write
    @(posedge clk); #1 rst_n = 0;
    @(posedge clk); #1 rst_n = 1;
    @(negedge clk);
    chk("R10 dropped", {31'd0, ram_wr_req}, 0);
    drive(0, 1, 0, 8'h12, 0, 0, 0);
    chk("R10 read flows", {31'd0, ram_rd_req}, 1);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule